// File: doc/BRIEF.md
# Descriptor-Chain Receive DMA Channel

This block is one receive DMA channel. It takes a packet that arrives as a byte stream and stores it in memory buffers described by a linked list of descriptors. Software loads a queue head pointer and builds the chain. Each descriptor is four 32-bit words at consecutive addresses:

- link to the next descriptor (0 ends the chain)
- buffer address
- buffer size in bytes
- status word

Software sets the ownership bit in the status word of the descriptor where the next packet may start. The channel then fills buffers one after another and moves on to the next descriptor each time a buffer is full. When the last byte has been stored, it writes status back into the descriptors the packet used. The first descriptor receives the byte count, and its ownership bit is cleared last. The channel then reports that descriptor's address on a completion output.

The channel uses a single memory port for everything. Descriptor reads return their data one cycle after the request. Byte stores go through a byte-enable mask. If no owned descriptor is available, the channel drains the packet and raises a one-cycle starvation pulse. The next packet starts on the descriptor that follows the last one the previous packet used.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is held, and in the cycle after it, `in_ready_o`, `starve_o`, `cmpl_valid_o`, `mem_rd_o` and `mem_wr_o` are 0 and `cmpl_ptr_o` is 0.
- R2: The status word layout is: bit 31 first-buffer flag, bit 30 last-buffer flag, bit 29 ownership, bit 28 end-of-queue, bit 23 empty-packet flag, bits 15:0 byte count. All other bits are written as 0, and ownership is always written as 0. A packet that fits in one buffer writes `0xC0000000 | count` (plus bit 28 when the link is 0). Its byte k lands at buffer address + k.
- R3: A packet longer than one buffer fills each buffer completely before the channel fetches the next descriptor. The first descriptor gets bit 31 and the byte count. Each middle descriptor gets a status of 0. The last descriptor gets bit 30 and a count field of 0.
- R4: Bit 28 is set only in the status of the packet's last descriptor, and only when that descriptor's link word is 0.
- R5: Buffer bytes past the end of a short packet are left unchanged. If the chain ends before the packet does, the remaining bytes are accepted and discarded. The byte count then equals the number of bytes stored.
- R6: A packet marked empty (`in_last_i` and `in_zero_i` on its only beat) stores no data. It writes `0xC0800000` (plus bit 28 when the link is 0) to its descriptor.
- R7: The first descriptor's status is written after every other status word of the packet. In the next cycle `cmpl_valid_o` pulses for one cycle, with `cmpl_ptr_o` holding that descriptor's address.
- R8: The next packet starts on the descriptor linked from the previous packet's last descriptor. A head load while a packet is in progress is ignored.
- R9: If a packet arrives while the head pointer is 0, or while the head descriptor's ownership bit is 0, the packet is drained. `starve_o` pulses for exactly one cycle, nothing is written to memory and the head pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_wr_i | input | 1 | Load the queue head pointer (taken only while idle) |
| head_ptr_i | input | AW | Queue head descriptor address |
| in_valid_i | input | 1 | Stream beat valid |
| in_data_i | input | 8 | Stream data byte |
| in_last_i | input | 1 | Beat is the last of the packet |
| in_zero_i | input | 1 | With `in_last_i`: the beat carries no data byte |
| in_ready_o | output | 1 | Channel accepts a beat |
| mem_rd_o | output | 1 | Word read request; data is expected one cycle later |
| mem_wr_o | output | 1 | Write request |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 4 | Byte enables for the write |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| cmpl_valid_o | output | 1 | One-cycle completion pulse |
| cmpl_ptr_o | output | AW | Address of the last completed packet's first descriptor |
| starve_o | output | 1 | One-cycle pulse when a packet is dropped |

## Verification
The bench builds the channel with `AW = 14`. This gives a 16 KiB memory model that is small enough to hold every descriptor and buffer, so the model can be read back byte by byte. With that space the bench can lay out:

- several separate chains
- a chain that ends exactly on a buffer boundary
- a chain that runs out in the middle of a packet

Each packet's data is checked at its final addresses, together with the guard bytes beyond it. The bench also reuses the head pointer left by one packet for the next, to confirm where the following packet starts.

// File: rtl/rxdma_pkg.sv
// Package for the receive DMA channel: status word bit positions,
// descriptor word offsets and the channel state encoding.
package rxdma_pkg;

    localparam int ST_SOP_BIT = 31;
    localparam int ST_EOP_BIT = 30;
    localparam int ST_OWN_BIT = 29;
    localparam int ST_EOQ_BIT = 28;
    localparam int ST_ZB_BIT  = 23;
    localparam int LEN_W      = 16;

    localparam int DESC_WORDS   = 4;
    localparam int STATUS_OFFS  = 12;

    typedef enum logic [3:0] {
        CH_IDLE,
        CH_FETCH_REQ,
        CH_FETCH_WAIT,
        CH_STREAM,
        CH_LINK,
        CH_TRUNC,
        CH_END_CUR,
        CH_END_SOP,
        CH_DROP
    } ch_state_t;

endpackage

// File: rtl/rxdma_status_pack.sv
// Builds a descriptor status word from its fields.
// Assumes: reserved positions are written as zero.
module rxdma_status_pack
    import rxdma_pkg::*;
(
    input  logic             sop_i,
    input  logic             eop_i,
    input  logic             own_i,
    input  logic             eoq_i,
    input  logic             zb_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [31:0]      word_o
);

    // Place each field at its position; everything else is zero.
    always_comb begin
        word_o             = '0;
        word_o[ST_SOP_BIT] = sop_i;
        word_o[ST_EOP_BIT] = eop_i;
        word_o[ST_OWN_BIT] = own_i;
        word_o[ST_EOQ_BIT] = eoq_i;
        word_o[ST_ZB_BIT]  = zb_i;
        word_o[LEN_W-1:0]  = len_i;
    end

endmodule

// File: rtl/rxdma_byte_lane.sv
// Steers one stream byte onto a 32-bit memory word.
// Assumes: little-endian lanes, byte address bits [1:0] select the lane.
module rxdma_byte_lane #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lane_i,
    input  logic [7:0]               byte_i,
    output logic [LANES-1:0]         be_o,
    output logic [8*LANES-1:0]       wdata_o
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Replicate the byte and enable only the addressed lane.
            assign wdata_o[8*g +: 8] = byte_i;
            assign be_o[g]           = (lane_i == g);
        end
    endgenerate

endmodule

// File: rtl/rx_desc_dma.sv
// Single receive DMA channel. Walks a descriptor chain from the queue
// head, stores stream bytes into the buffers, writes back status words
// and reports the first descriptor of each completed packet.
// Assumes: descriptors are 16-byte aligned, buffer sizes are nonzero,
// memory read data arrives one cycle after mem_rd_o, writes take effect
// at the clock edge that samples mem_wr_o.
module rx_desc_dma
    import rxdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_wr_i,
    input  logic [AW-1:0] head_ptr_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    input  logic          in_last_i,
    input  logic          in_zero_i,
    output logic          in_ready_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [3:0]    mem_be_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          cmpl_valid_o,
    output logic [AW-1:0] cmpl_ptr_o,
    output logic          starve_o
);

    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [AW-1:0] STAT_OFF = AW'(STATUS_OFFS);

    ch_state_t        state_q;
    logic [AW-1:0]    head_q, cur_q, sop_q, nxt_q, bptr_q, cmpl_q;
    logic [LEN_W-1:0] brem_q, plen_q;
    logic [IDX_W-1:0] idx_q;
    logic             is_sop_q, cmpl_v_q, starve_q;

    logic             accept, data_beat, last_word, eoq;
    logic [3:0]       lane_be;
    logic [31:0]      lane_data, cur_status, sop_status;
    logic             rdata_unused;

    assign rdata_unused = ^mem_rdata_i;
    assign in_ready_o   = (state_q == CH_STREAM) || (state_q == CH_TRUNC) ||
                          (state_q == CH_DROP);
    assign accept       = in_ready_o && in_valid_i;
    assign data_beat    = !(in_last_i && in_zero_i);
    assign last_word    = is_sop_q ? (idx_q == IDX_W'(3)) : (idx_q == IDX_W'(2));
    assign eoq          = (nxt_q == '0);

    rxdma_byte_lane #(.LANES(4)) u_lane (
        .lane_i  (bptr_q[1:0]),
        .byte_i  (in_data_i),
        .be_o    (lane_be),
        .wdata_o (lane_data)
    );

    rxdma_status_pack u_cur_stat (
        .sop_i  (is_sop_q),
        .eop_i  (1'b1),
        .own_i  (1'b0),
        .eoq_i  (eoq),
        .zb_i   (is_sop_q && (plen_q == '0)),
        .len_i  (is_sop_q ? plen_q : '0),
        .word_o (cur_status)
    );

    rxdma_status_pack u_sop_stat (
        .sop_i  (1'b1),
        .eop_i  (1'b0),
        .own_i  (1'b0),
        .eoq_i  (1'b0),
        .zb_i   (1'b0),
        .len_i  (plen_q),
        .word_o (sop_status)
    );

    // Memory port: one operation per cycle chosen by the channel state.
    always_comb begin
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_be_o    = 4'hF;
        mem_wdata_o = '0;
        case (state_q)
            CH_FETCH_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = cur_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
            end
            CH_STREAM: begin
                mem_wr_o    = accept && data_beat;
                mem_addr_o  = bptr_q;
                mem_be_o    = lane_be;
                mem_wdata_o = lane_data;
            end
            CH_LINK: begin
                mem_wr_o   = !is_sop_q;
                mem_addr_o = cur_q + STAT_OFF;
            end
            CH_END_CUR: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = cur_q + STAT_OFF;
                mem_wdata_o = cur_status;
            end
            CH_END_SOP: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = sop_q + STAT_OFF;
                mem_wdata_o = sop_status;
            end
            default: ;
        endcase
    end

    // Channel sequencer and scratch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_IDLE;
            head_q   <= '0;
            cur_q    <= '0;
            sop_q    <= '0;
            nxt_q    <= '0;
            bptr_q   <= '0;
            cmpl_q   <= '0;
            brem_q   <= '0;
            plen_q   <= '0;
            idx_q    <= '0;
            is_sop_q <= 1'b0;
            cmpl_v_q <= 1'b0;
            starve_q <= 1'b0;
        end else begin
            cmpl_v_q <= 1'b0;
            starve_q <= 1'b0;
            case (state_q)
                CH_IDLE: begin
                    if (head_wr_i) begin
                        head_q <= head_ptr_i;
                    end else if (in_valid_i) begin
                        if (head_q == '0) begin
                            starve_q <= 1'b1;
                            state_q  <= CH_DROP;
                        end else begin
                            cur_q    <= head_q;
                            sop_q    <= head_q;
                            is_sop_q <= 1'b1;
                            idx_q    <= '0;
                            plen_q   <= '0;
                            state_q  <= CH_FETCH_REQ;
                        end
                    end
                end
                CH_FETCH_REQ: state_q <= CH_FETCH_WAIT;
                CH_FETCH_WAIT: begin
                    case (idx_q)
                        IDX_W'(0): nxt_q  <= mem_rdata_i[AW-1:0];
                        IDX_W'(1): bptr_q <= mem_rdata_i[AW-1:0];
                        IDX_W'(2): brem_q <= mem_rdata_i[LEN_W-1:0];
                        default: ;
                    endcase
                    if (!last_word) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= CH_FETCH_REQ;
                    end else if (is_sop_q && !mem_rdata_i[ST_OWN_BIT]) begin
                        starve_q <= 1'b1;
                        state_q  <= CH_DROP;
                    end else begin
                        state_q <= CH_STREAM;
                    end
                end
                CH_STREAM: begin
                    if (accept) begin
                        if (data_beat) begin
                            bptr_q <= bptr_q + 1'b1;
                            brem_q <= brem_q - 1'b1;
                            plen_q <= plen_q + 1'b1;
                        end
                        if (in_last_i)
                            state_q <= CH_END_CUR;
                        else if (brem_q == LEN_W'(1))
                            state_q <= eoq ? CH_TRUNC : CH_LINK;
                    end
                end
                CH_LINK: begin
                    cur_q    <= nxt_q;
                    is_sop_q <= 1'b0;
                    idx_q    <= '0;
                    state_q  <= CH_FETCH_REQ;
                end
                CH_TRUNC: if (accept && in_last_i) state_q <= CH_END_CUR;
                CH_END_CUR: begin
                    if (is_sop_q) begin
                        head_q   <= nxt_q;
                        cmpl_q   <= sop_q;
                        cmpl_v_q <= 1'b1;
                        state_q  <= CH_IDLE;
                    end else begin
                        state_q <= CH_END_SOP;
                    end
                end
                CH_END_SOP: begin
                    head_q   <= nxt_q;
                    cmpl_q   <= sop_q;
                    cmpl_v_q <= 1'b1;
                    state_q  <= CH_IDLE;
                end
                CH_DROP: if (accept && in_last_i) state_q <= CH_IDLE;
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    assign cmpl_valid_o = cmpl_v_q;
    assign cmpl_ptr_o   = cmpl_q;
    assign starve_o     = starve_q;

    AST_STARVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        starve_o |=> !starve_o); // R9
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DROP) |-> !mem_wr_o); // R9
    AST_CMPL_AFTER_SOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid_o |-> ($past(mem_wr_o) && ($past(mem_addr_o) == cmpl_ptr_o + STAT_OFF))); // R7
    AST_NO_BUF_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_STREAM) && mem_wr_o) |-> (brem_q != '0)); // R5
    AST_OWN_WRITTEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && (mem_be_o == 4'hF)) |-> !mem_wdata_o[ST_OWN_BIT]); // R2
    AST_EMPTY_HAS_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && (mem_be_o == 4'hF) && mem_wdata_o[ST_ZB_BIT]) |-> (mem_wdata_o[LEN_W-1:0] == '0)); // R6
    AST_EOQ_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && (mem_be_o == 4'hF) && mem_wdata_o[ST_EOQ_BIT]) |-> mem_wdata_o[ST_EOP_BIT]); // R4

endmodule

// File: tb/rx_desc_dma_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the packet driver queues expected completions, a
// monitor pops and compares them when the channel reports one.
module rx_desc_dma_tb_top;

    localparam int AW   = 14;
    localparam int MEMW = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          head_wr_i = 1'b0;
    logic [AW-1:0] head_ptr_i = '0;
    logic          in_valid_i = 1'b0;
    logic [7:0]    in_data_i = '0;
    logic          in_last_i = 1'b0;
    logic          in_zero_i = 1'b0;
    logic          in_ready_o, mem_rd_o, mem_wr_o, cmpl_valid_o, starve_o;
    logic [AW-1:0] mem_addr_o, cmpl_ptr_o;
    logic [3:0]    mem_be_o;
    logic [31:0]   mem_wdata_o;
    logic [31:0]   mem_rdata_i = '0;

    logic [31:0] mem [0:MEMW-1];
    logic [31:0] exp_ptr_q[$];
    logic [31:0] exp_word_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int starve_cnt = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;

    rx_desc_dma #(.AW(AW)) dut_i (
        .clk, .rst_n, .head_wr_i, .head_ptr_i, .in_valid_i, .in_data_i,
        .in_last_i, .in_zero_i, .in_ready_o, .mem_rd_o, .mem_wr_o,
        .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_rdata_i, .cmpl_valid_o,
        .cmpl_ptr_o, .starve_o
    );

    // Memory model with one-cycle read latency and byte enables.
    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o >> 2];
        if (mem_wr_o) begin
            for (int b = 0; b < 4; b++)
                if (mem_be_o[b]) mem[mem_addr_o >> 2][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end
    end

    // Event counters for starvation pulses and memory writes.
    always @(posedge clk) begin
        if (rst_n && starve_o) starve_cnt <= starve_cnt + 1;
        if (rst_n && mem_wr_o) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input int addr);
        return mem[addr >> 2][8*(addr % 4) +: 8];
    endfunction

    // Monitor: compare each completion against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && cmpl_valid_o) begin
            if (exp_ptr_q.size() == 0) begin
                chk("R7 unexpected completion", 32'(cmpl_ptr_o), 32'hFFFF_FFFF);
            end else begin
                logic [31:0] p, w;
                p = exp_ptr_q.pop_front();
                w = exp_word_q.pop_front();
                chk("R7 completion pointer", 32'(cmpl_ptr_o), p);
                chk("R2 first descriptor status", mem[(cmpl_ptr_o >> 2) + 3], w);
            end
        end
    end

    task automatic mk_desc(input int a, input int nxt, input int buf_a, input int len, input bit own);
        mem[a >> 2]     = 32'(nxt);
        mem[(a >> 2)+1] = 32'(buf_a);
        mem[(a >> 2)+2] = 32'(len);
        mem[(a >> 2)+3] = own ? 32'h2000_0000 : 32'h0;
    endtask

    task automatic load_head(input int a);
        head_wr_i = 1'b1;
        head_ptr_i = AW'(a);
        @(negedge clk);
        head_wr_i = 1'b0;
    endtask

    task automatic beat(input logic [7:0] d, input bit last, input bit zero);
        in_valid_i = 1'b1;
        in_data_i  = d;
        in_last_i  = last;
        in_zero_i  = zero;
        while (!in_ready_o) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Driver: send a packet and push the expected completion if any.
    task automatic send_pkt(input int n, input logic [7:0] base, input bit zero,
                            input bit expect_done, input int sop, input logic [31:0] word);
        if (expect_done) begin
            exp_ptr_q.push_back(32'(sop));
            exp_word_q.push_back(word);
        end
        if (zero) beat(8'h00, 1'b1, 1'b1);
        else for (int i = 0; i < n; i++) beat(base + 8'(i), i == n - 1, 1'b0);
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        in_zero_i  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic chk_bytes(input string req, input int a, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) chk(req, 32'(rdb(a + i)), 32'(base + 8'(i)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0, s0;
        for (int i = 0; i < MEMW; i++) mem[i] = 32'hEEEE_EEEE;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 in_ready", 32'(in_ready_o), 0);
        chk("R1 starve", 32'(starve_o), 0);
        chk("R1 cmpl_valid", 32'(cmpl_valid_o), 0);
        chk("R1 cmpl_ptr", 32'(cmpl_ptr_o), 0);
        chk("R1 mem ops", 32'({mem_rd_o, mem_wr_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({in_ready_o, starve_o, cmpl_valid_o, mem_rd_o, mem_wr_o}), 0);

        // R9: head pointer zero
        w0 = wr_cnt;
        send_pkt(3, 8'h01, 0, 0, 0, 0);
        chk("R9 starve pulse on null head", 32'(starve_cnt), 1);
        chk("R9 no write on null head", 32'(wr_cnt), 32'(w0));

        mk_desc(12'h100, 12'h110, 16'h1000, 8, 1);
        mk_desc(12'h110, 12'h120, 16'h1010, 8, 1);
        mk_desc(12'h120, 12'h130, 16'h1020, 8, 1);
        mk_desc(12'h130, 12'h140, 16'h1030, 8, 1);
        mk_desc(12'h140, 0,       16'h1040, 8, 1);
        load_head(12'h100);

        // R2: single buffer, R5 guard byte
        send_pkt(5, 8'h10, 0, 1, 12'h100, 32'hC000_0005);
        chk_bytes("R2 single buffer data", 16'h1000, 5, 8'h10);
        chk("R5 byte past short packet", 32'(rdb(16'h1005)), 32'hEE);

        // R3: three buffers; R8 head load during the packet is ignored
        fork
            send_pkt(20, 8'h40, 0, 1, 12'h110, 32'h8000_0014);
            begin
                repeat (6) @(negedge clk);
                head_wr_i = 1'b1;
                head_ptr_i = 14'h0700;
                @(negedge clk);
                head_wr_i = 1'b0;
            end
        join
        chk_bytes("R3 first buffer", 16'h1010, 8, 8'h40);
        chk_bytes("R3 second buffer", 16'h1020, 8, 8'h48);
        chk_bytes("R3 third buffer", 16'h1030, 4, 8'h50);
        chk("R3 middle status", mem[(12'h120 >> 2) + 3], 32'h0);
        chk("R4 last status no eoq", mem[(12'h130 >> 2) + 3], 32'h4000_0000);
        chk("R5 byte after third buffer data", 32'(rdb(16'h1034)), 32'hEE);

        // R6 + R8: empty packet lands on the next descriptor, end of queue
        send_pkt(0, 8'h00, 1, 1, 12'h140, 32'hD080_0000);
        chk("R6 no data stored", mem[16'h1040 >> 2], 32'hEEEE_EEEE);

        // R4: packet ends exactly on the chain end
        mk_desc(12'h200, 12'h210, 16'h2000, 4, 1);
        mk_desc(12'h210, 0,       16'h2010, 4, 1);
        load_head(12'h200);
        send_pkt(8, 8'h80, 0, 1, 12'h200, 32'h8000_0008);
        chk("R4 last status with eoq", mem[(12'h210 >> 2) + 3], 32'h5000_0000);
        chk_bytes("R3 exact fill data", 16'h2010, 4, 8'h84);

        // R5: chain shorter than the packet
        mk_desc(12'h300, 0, 16'h3000, 4, 1);
        load_head(12'h300);
        send_pkt(7, 8'hA0, 0, 1, 12'h300, 32'hD000_0004);
        chk_bytes("R5 stored part", 16'h3000, 4, 8'hA0);
        chk("R5 discarded part", mem[16'h3004 >> 2], 32'hEEEE_EEEE);

        // R9: head descriptor not owned, then retry once owned
        mk_desc(12'h400, 0, 16'h3800, 4, 0);
        load_head(12'h400);
        w0 = wr_cnt;
        s0 = starve_cnt;
        send_pkt(2, 8'hB0, 0, 0, 0, 0);
        chk("R9 starve pulse on unowned", 32'(starve_cnt - s0), 1);
        chk("R9 no write on unowned", 32'(wr_cnt), 32'(w0));
        chk("R9 status untouched", mem[(12'h400 >> 2) + 3], 32'h0);
        mem[(12'h400 >> 2) + 3] = 32'h2000_0000;
        send_pkt(1, 8'hC0, 0, 1, 12'h400, 32'hD000_0001);
        chk("R9 retry data", 32'(rdb(16'h3800)), 32'hC0);

        chk("R7 all completions seen", 32'(exp_ptr_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule